// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block sits between five interrupt sources and a processor core. It masks each source with its own enable bit and with one global enable. It gives every source one of two priority levels and presents at most one request to the core. With that request it supplies a fixed vector address. The five sources are external line 0, timer 0 overflow, external line 1, timer 1 overflow and the serial port. The serial source is raised when either its receive-complete flag or its transmit-complete flag is set.

The controller keeps one in-service bit for each priority level. The core pulses `irq_ack` when it takes the presented request. That pulse marks the request's level as in service. For timer sources, and for external sources set to edge mode, it also sends a one-cycle clear pulse back to the source flag. The core pulses `irq_ret` when a handler finishes. While a low-level handler runs, only high-level requests are presented, so they can nest on top of it. While a high-level handler runs, nothing is presented. When no request is presented, the vector output reads 0000h, which is the reset location.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A source is pending only when its flag, its enable bit in `src_en` and `glob_en` are all 1. When `glob_en` is 0, `irq_valid` is 0.
- R2: The serial source (bit 4 of `src_en`/`src_hi`) is the OR of `ser_rx_done` and `ser_tx_done`. Either flag alone raises it with the same vector.
- R3: The vector for source index k is 0003h + 8·k. Index 0 is external 0, 1 is timer 0, 2 is external 1, 3 is timer 1 and 4 is serial, giving 0003h, 000Bh, 0013h, 001Bh and 0023h. While `irq_valid` is 0, `irq_vector` is 0000h. `irq_sel` is one-hot on bit k.
- R4: Among pending sources of the same level, the lowest index is presented.
- R5: With no level in service, a pending high-level source (`src_hi` bit = 1) is presented ahead of every low-level source.
- R6: While only the low level is in service (`in_service` = 01b), only high-level sources are presented.
- R7: While the high level is in service (`in_service[1]` = 1), no request is presented.
- R8: On a clock edge with `irq_ack` = 1 and `irq_valid` = 1, the in-service bit of the presented source's level is set (bit 1 high, bit 0 low). `irq_ack` while `irq_valid` is 0 has no effect.
- R9: On a clock edge with `irq_ret` = 1, the high in-service bit is cleared if it is set; otherwise the low bit is cleared. If `irq_ack` is taken in the same cycle, the return is applied first and then the acknowledge. A return with no level in service has no effect.
- R10: A taken acknowledge drives `flag_clr` combinationally in that cycle. Bit 0 is external 0, bit 1 timer 0, bit 2 external 1 and bit 3 timer 1. Timer bits always pulse. An external bit pulses only when its `ext_edge` bit is 1. Serial never produces a clear.
- R11: After reset `in_service` is 00b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext0_req | input | 1 | External line 0 request flag |
| tmr0_ovf | input | 1 | Timer 0 overflow flag |
| ext1_req | input | 1 | External line 1 request flag |
| tmr1_ovf | input | 1 | Timer 1 overflow flag |
| ser_rx_done | input | 1 | Serial receive-complete flag |
| ser_tx_done | input | 1 | Serial transmit-complete flag |
| ext_edge | input | 2 | Per external line: 1 = edge type (cleared on acknowledge) |
| src_en | input | 5 | Per-source enable, indexed by source number |
| glob_en | input | 1 | Global enable |
| src_hi | input | 5 | Per-source level, 1 = high |
| irq_ack | input | 1 | Core takes the presented request |
| irq_ret | input | 1 | Core finished a handler |
| irq_valid | output | 1 | A request is presented |
| irq_sel | output | 5 | One-hot presented source |
| irq_vector | output | VEC_W | Vector address of presented source, else 0 |
| flag_clr | output | 4 | Clear pulses to source flags |
| in_service | output | 2 | In-service bits, [1] high, [0] low |

## Verification
The bench builds the block with its default parameters: a 16-bit vector, base 0003h and step 8. These values put the full vector table within reach. A directed stage covers each ordering and nesting corner: a high request nesting on a low handler, a return issued while both levels are in service, an acknowledge with nothing presented, and every edge/level setting of the external lines. A long stage with random flags, masks, levels, acknowledges and returns then drives the controller through every combination of in-service states. A behavioural model in the bench is compared against all outputs on every clock.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int VEC_W    = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext0_req,
  input  logic             tmr0_ovf,
  input  logic             ext1_req,
  input  logic             tmr1_ovf,
  input  logic             ser_rx_done,
  input  logic             ser_tx_done,
  input  logic [1:0]       ext_edge,
  input  logic [4:0]       src_en,
  input  logic             glob_en,
  input  logic [4:0]       src_hi,
  input  logic             irq_ack,
  input  logic             irq_ret,
  output logic             irq_valid,
  output logic [4:0]       irq_sel,
  output logic [VEC_W-1:0] irq_vector,
  output logic [3:0]       flag_clr,
  output logic [1:0]       in_service
);
  localparam int NSRC = 5;

  logic [NSRC-1:0] flags, pend, hi_pend, lo_pend, cand;
  logic [VEC_W-1:0] idx;
  logic take, sel_hi;

  assign flags   = {ser_rx_done | ser_tx_done, tmr1_ovf, ext1_req, tmr0_ovf, ext0_req};
  assign pend    = flags & src_en & {NSRC{glob_en}};
  assign hi_pend = pend & src_hi;
  assign lo_pend = pend & ~src_hi;

  assign cand = in_service[1] ? '0 :
                (|hi_pend)    ? hi_pend :
                in_service[0] ? '0 : lo_pend;

  assign irq_sel   = cand & (~cand + 1'b1);
  assign irq_valid = |cand;

  always_comb begin
    idx = '0;
    for (int i = NSRC-1; i >= 0; i--)
      if (irq_sel[i]) idx = VEC_W'(i);
  end

  assign irq_vector = irq_valid ? VEC_W'(VEC_BASE + int'(idx) * VEC_STEP) : '0;

  assign take   = irq_ack & irq_valid;
  assign sel_hi = |(irq_sel & src_hi);

  assign flag_clr = {4{take}} & irq_sel[3:0] & {1'b1, ext_edge[1], 1'b1, ext_edge[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_service <= 2'b00;
    end else begin
      in_service[1] <= (in_service[1] & ~irq_ret) | (take & sel_hi);
      in_service[0] <= (in_service[0] & ~(irq_ret & ~in_service[1])) | (take & ~sel_hi);
    end
  end
endmodule

module irq_prio_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       glob_en,
  input logic [4:0] src_hi,
  input logic       irq_ack,
  input logic       irq_ret,
  input logic       irq_valid,
  input logic [4:0] irq_sel,
  input logic [15:0] irq_vector,
  input logic [3:0] flag_clr,
  input logic [1:0] in_service
);
  p_glob_gate_r1: assert property (@(posedge clk) disable iff (!rst_n) !glob_en |-> !irq_valid);
  p_idle_vec_r3: assert property (@(posedge clk) disable iff (!rst_n) !irq_valid |-> irq_vector == 16'h0);
  p_sel_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(irq_sel) && (irq_valid == (irq_sel != 0)));
  p_nest_hi_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_service == 2'b01 && irq_valid) |-> (irq_sel & src_hi) != 0);
  p_hi_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n) in_service[1] |-> !irq_valid);
  p_ack_marks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_valid && !irq_ret) |=> in_service != 2'b00);
  p_ret_hi_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && !irq_ack && in_service == 2'b11) |=> in_service == 2'b01);
  p_clr_on_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr != 0) |-> (irq_ack && irq_valid && $countones(flag_clr) == 1));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .src_hi(src_hi),
  .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_valid(irq_valid), .irq_sel(irq_sel),
  .irq_vector(irq_vector[15:0]), .flag_clr(flag_clr), .in_service(in_service)
);

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic ext0_req = 0, tmr0_ovf = 0, ext1_req = 0, tmr1_ovf = 0, ser_rx_done = 0, ser_tx_done = 0;
  logic [1:0] ext_edge = 0;
  logic [4:0] src_en = 0, src_hi = 0;
  logic glob_en = 0, irq_ack = 0, irq_ret = 0;
  logic irq_valid;
  logic [4:0] irq_sel;
  logic [15:0] irq_vector;
  logic [3:0] flag_clr;
  logic [1:0] in_service;

  int checks = 0, fails = 0;
  bit done = 0;
  bit m_hi = 0, m_lo = 0;

  always #5 clk = ~clk;

  irq_prio_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ext0_req(ext0_req), .tmr0_ovf(tmr0_ovf), .ext1_req(ext1_req),
    .tmr1_ovf(tmr1_ovf), .ser_rx_done(ser_rx_done), .ser_tx_done(ser_tx_done), .ext_edge(ext_edge),
    .src_en(src_en), .glob_en(glob_en), .src_hi(src_hi), .irq_ack(irq_ack), .irq_ret(irq_ret),
    .irq_valid(irq_valid), .irq_sel(irq_sel), .irq_vector(irq_vector), .flag_clr(flag_clr),
    .in_service(in_service)
  );

  task automatic cmp(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural model: scan levels high then low, sources in order, first allowed hit wins.
  task automatic model(output bit v, output int k);
    bit fl[5];
    fl[0] = ext0_req; fl[1] = tmr0_ovf; fl[2] = ext1_req; fl[3] = tmr1_ovf;
    fl[4] = ser_rx_done || ser_tx_done;          // R2
    v = 0; k = 0;
    for (int lvl = 1; lvl >= 0; lvl--) begin
      bit allowed;
      allowed = (lvl == 1) ? !m_hi : (!m_hi && !m_lo);   // R5 R6 R7
      if (allowed && !v)
        for (int i = 0; i < 5; i++)                        // R4
          if (!v && fl[i] && src_en[i] && glob_en && (src_hi[i] == lvl[0])) begin  // R1
            v = 1; k = i;
          end
    end
  endtask

  task automatic step();
    bit v; int k; int exp_clr;
    #1;
    model(v, k);
    exp_clr = 0;
    if (irq_ack && v && k < 4 && ((k % 2 == 1) || ext_edge[k/2])) exp_clr = 1 << k;  // R10
    cmp("R1 R4 R5 R6 R7 irq_valid", int'(irq_valid), int'(v));
    cmp("R3 irq_sel", int'(irq_sel), v ? (1 << k) : 0);
    cmp("R3 irq_vector", int'(irq_vector), v ? (3 + 8 * k) : 0);
    cmp("R10 flag_clr", int'(flag_clr), exp_clr);
    cmp("R8 R9 in_service", int'(in_service), {30'd0, m_hi, m_lo});
    @(posedge clk);
    if (irq_ret) begin                              // R9
      if (m_hi) m_hi = 0; else m_lo = 0;
    end
    if (irq_ack && v) begin                         // R8
      if (src_hi[k]) m_hi = 1; else m_lo = 1;
    end
    @(negedge clk);
  endtask

  task automatic set_flags(input logic [5:0] f);
    {ser_tx_done, ser_rx_done, tmr1_ovf, ext1_req, tmr0_ovf, ext0_req} = f;
  endtask

  task automatic pulse_ack();
    irq_ack = 1; step(); irq_ack = 0;
  endtask

  task automatic pulse_ret();
    irq_ret = 1; step(); irq_ret = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    step();                                 // R11 reset state
    rst_n = 1;
    @(negedge clk);
    step();
    // R1: flags set, global off
    set_flags(6'b011111); src_en = 5'b11111; glob_en = 0; step();
    // R1: per-source mask
    glob_en = 1; src_en = 5'b00000; step();
    src_en = 5'b11111;
    // R4: fixed order within low level
    for (int i = 0; i < 5; i++) begin
      set_flags(6'b011111 & ~((6'd1 << i) - 6'd1)); step();
    end
    // R2: each serial flag alone, vector 0023h
    set_flags(6'b010000); step();
    set_flags(6'b100000); step();
    // R5: high beats low
    set_flags(6'b011111); src_hi = 5'b01000; step();
    // R8 R6: take low, then only high visible
    src_hi = 5'b00000; set_flags(6'b000101); pulse_ack();
    step();
    src_hi = 5'b10000; set_flags(6'b100101); step();
    // R8 R7: nest high, then nothing
    pulse_ack(); step();
    // R9: return clears high first, then low
    pulse_ret(); step();
    pulse_ret(); step();
    // R9: return with nothing in service
    pulse_ret(); step();
    // R8: ack with nothing presented is ignored
    set_flags(6'b0); pulse_ack(); step();
    // R10: clear pulses in every edge mode
    src_hi = 5'b0;
    for (int m = 0; m < 4; m++) begin
      ext_edge = m[1:0];
      for (int i = 0; i < 5; i++) begin
        set_flags(6'd1 << i); pulse_ack(); pulse_ret();
      end
    end
    // R9: ack and return in the same cycle
    set_flags(6'b000010); pulse_ack();
    src_hi = 5'b00001; set_flags(6'b000001); irq_ack = 1; irq_ret = 1; step();
    irq_ack = 0; irq_ret = 0; step();
    pulse_ret(); pulse_ret(); step();
    // Random stage
    for (int n = 0; n < 20000; n++) begin
      set_flags(6'($urandom));
      src_en = 5'($urandom | $urandom);
      src_hi = 5'($urandom);
      glob_en = ($urandom % 8) != 0;
      ext_edge = 2'($urandom);
      irq_ack = ($urandom % 3) == 0;
      irq_ret = ($urandom % 4) == 0;
      step();
    end
    irq_ack = 0; irq_ret = 0;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule